// File: doc/BRIEF.md
# Vector Length State Register

This block holds the live vector-length context of an element-looping execution unit in one 30-bit packed word. The word carries the maximum vector length, the current vector length, the sub-vector group size, the whole-element source and destination offsets, and the sub-element source and destination offsets. The two lengths and the group size are kept minus one. Six bits therefore cover every length from 1 up to 64.

Software reaches the block through one access port. The port can address the whole packed word or either length on its own, and it can write, set bits or clear bits. Every result is forced into range before it is stored:
- the maximum length is capped by a parameter;
- the current length never exceeds the maximum;
- each offset never exceeds its length field.

The element loop loads all four offsets at once through a separate port. When execution enters or leaves a privilege level, an external shadow copy is exchanged with the live word in a single cycle.

Top module: `vlen_state_csr`

## Requirements
- R1: After reset the packed word reads 0x0000003F: maximum length 64, current length 1, group size 1, and all offsets 0.
- R2: Packed layout (bit positions):
  - maximum length field: bits 5:0
  - current length field: bits 11:6
  - source offset: bits 17:12
  - destination offset: bits 23:18
  - group size field: bits 25:24
  - source sub-offset: bits 27:26
  - destination sub-offset: bits 29:28

  The length and group-size fields hold the value minus one. `vlLen` and `maxLen` show the decoded lengths (field + 1).
- R3: The current-length field is never stored above the maximum-length field. A write that asks for more stores the maximum.
- R4: A write to the current-length target (swTarget=1, swOp=0) with requested length L stores MIN(L, maximum). L=0 is treated as 1. `lenOut` returns the stored length in the cycle of the request.
- R5: A write to the maximum-length target (swTarget=2) stores MIN(L, MAXLEN), again with 0 treated as 1. If the current length is above the new maximum, it is reduced to that maximum.
- R6: With `swImm` set on a write (swOp=0) to a length target, the requested length is swData+1.
- R7: swOp=1 ORs swData into the target and swOp=2 clears the swData bits in the target. On a length target these act on the decoded length, and the result is then clamped as in R4/R5. swOp=3 changes nothing.
- R8: Bits 31:30 of the word and all `rdData` bits above 29 read zero. Writes to them are ignored.
- R9: Each whole-element offset is clamped to at most the current-length field. Each sub-element offset is clamped to at most the group-size field.
- R10: `loopEn` loads all four offset fields in one cycle. A software access to a real target (swTarget≠3, swOp≠3) in the same cycle wins, and the loop load is dropped.
- R11: `stateOut` always presents the live word for the shadow to capture. `swapEn` replaces the live word with the range-forced `swapIn` at the next edge. A swap wins over software and loop loads.
- R12: `rdData` presents, combinationally, the pre-update value of the addressed target:
  - swTarget=0: the packed word
  - swTarget=1: the current length
  - swTarget=2: the maximum length
  - swTarget=3: zero; writes to this target are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swEn | input | 1 | Software access strobe |
| swOp | input | 2 | 0 write, 1 set bits, 2 clear bits, 3 none |
| swTarget | input | 2 | 0 packed word, 1 current length, 2 maximum length, 3 none |
| swImm | input | 1 | Immediate form: requested length is swData+1 |
| swData | input | DATA_W | Software write data |
| rdData | output | DATA_W | Pre-update value of the addressed target |
| lenOut | output | 7 | Length a length-target access stores |
| loopEn | input | 1 | Loop offset load strobe |
| loopSrcOffs | input | 6 | New source offset |
| loopDstOffs | input | 6 | New destination offset |
| loopSrcSub | input | 2 | New source sub-offset |
| loopDstSub | input | 2 | New destination sub-offset |
| swapEn | input | 1 | Privilege change: load swapIn |
| swapIn | input | 32 | Shadow word to load |
| stateOut | output | 32 | Live packed word |
| vlLen | output | 7 | Decoded current length |
| maxLen | output | 7 | Decoded maximum length |

## Verification
Length requests are driven below, at and above the limit, including zero. This separates the minus-one storage from the clamp and from the zero-to-one floor. Packed-word writes with an oversize length, oversize offsets and the top two bits set show that range forcing is applied to whole-word writes as well as to length writes. Set and clear are driven on both the packed word and the decoded lengths, which tells the two domains apart. Same-cycle collisions of swap, software and loop loads expose the priority order, and every clock is compared against a behavioural model.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int FIELD_W = 6;
  localparam int LEN_W   = FIELD_W + 1;
  localparam int WORD_W  = 32;

  typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_SET = 2'd1, OP_CLEAR = 2'd2, OP_NONE = 2'd3} swOp_e;
  typedef enum logic [1:0] {TGT_WORD = 2'd0, TGT_VL = 2'd1, TGT_MAXVL = 2'd2, TGT_NONE = 2'd3} swTgt_e;

  typedef struct packed {
    logic [1:0]         pad;
    logic [1:0]         dstSub;
    logic [1:0]         srcSub;
    logic [1:0]         subLen;
    logic [FIELD_W-1:0] dstOffs;
    logic [FIELD_W-1:0] srcOffs;
    logic [FIELD_W-1:0] curLen;
    logic [FIELD_W-1:0] maxLen;
  } stateWord_t;

  typedef struct packed {
    logic   takeSwap;
    logic   takeSw;
    logic   takeLoop;
    logic   immAdj;
    swOp_e  op;
    swTgt_e tgt;
  } strobe_t;

  // Force every field into range: cap, then length order, then offsets.
  function automatic stateWord_t legalize(input stateWord_t w, input logic [FIELD_W-1:0] cap);
    stateWord_t r;
    r = w;
    r.pad = 2'b00;
    if (r.maxLen > cap)      r.maxLen  = cap;
    if (r.curLen > r.maxLen) r.curLen  = r.maxLen;
    if (r.srcOffs > r.curLen) r.srcOffs = r.curLen;
    if (r.dstOffs > r.curLen) r.dstOffs = r.curLen;
    if (r.srcSub > r.subLen) r.srcSub  = r.subLen;
    if (r.dstSub > r.subLen) r.dstSub  = r.subLen;
    return r;
  endfunction
endpackage

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swEn,
  input  logic [1:0] swOp,
  input  logic [1:0] swTarget,
  input  logic       swImm,
  input  logic       loopEn,
  input  logic       swapEn,
  output strobe_t    stb
);
  swOp_e  opDec;
  swTgt_e tgtDec;
  logic   swReal;

  always_comb begin
    opDec  = swOp_e'(swOp);
    tgtDec = swTgt_e'(swTarget);
    swReal = swEn && (opDec != OP_NONE) && (tgtDec != TGT_NONE);
    stb.op       = opDec;
    stb.tgt      = tgtDec;
    stb.immAdj   = swImm && (opDec == OP_WRITE);
    stb.takeSwap = swapEn;
    stb.takeSw   = swReal && !swapEn;
    stb.takeLoop = loopEn && !swapEn && !swReal;
  end

  // R11: a privilege swap suppresses every other source
  assert_swap_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    swapEn |-> (!stb.takeSw && !stb.takeLoop));

  // R10: a real software access drops the loop load
  assert_sw_over_loop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (swEn && !swapEn && swOp != 2'd3 && swTarget != 2'd3) |-> !stb.takeLoop);
endmodule

// File: rtl/vls_datapath.sv
module vls_datapath
  import vls_pkg::*;
#(
  parameter int MAXLEN = 64,
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [DATA_W-1:0]  swData,
  input  logic [FIELD_W-1:0] loopSrcOffs,
  input  logic [FIELD_W-1:0] loopDstOffs,
  input  logic [1:0]         loopSrcSub,
  input  logic [1:0]         loopDstSub,
  input  logic [WORD_W-1:0]  swapIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [LEN_W-1:0]   lenOut,
  output logic [WORD_W-1:0]  stateOut,
  output logic [LEN_W-1:0]   vlLen,
  output logic [LEN_W-1:0]   maxLen
);
  localparam int REQ_W = DATA_W + 1;
  localparam logic [FIELD_W-1:0] CAP = FIELD_W'(MAXLEN - 1);
  localparam stateWord_t RESET_WORD = '{pad: 2'b0, dstSub: 2'b0, srcSub: 2'b0, subLen: 2'b0,
                                        dstOffs: '0, srcOffs: '0, curLen: '0, maxLen: CAP};

  stateWord_t st, swResult, loopResult, nextRaw, nextSt;
  logic [LEN_W-1:0]   curAct, maxAct, oldLen, limit, limitM1;
  logic [REQ_W-1:0]   req, dataExt;
  logic [FIELD_W-1:0] newLenField;
  logic [WORD_W-1:0]  wordNext;

  always_comb begin
    curAct  = {1'b0, st.curLen} + LEN_W'(1);
    maxAct  = {1'b0, st.maxLen} + LEN_W'(1);
    oldLen  = (stb.tgt == TGT_VL) ? curAct : maxAct;
    limit   = (stb.tgt == TGT_VL) ? maxAct : LEN_W'(MAXLEN);
    limitM1 = limit - LEN_W'(1);
    dataExt = {1'b0, swData};
    case (stb.op)
      OP_WRITE: req = dataExt + (stb.immAdj ? REQ_W'(1) : REQ_W'(0));
      OP_SET:   req = REQ_W'(oldLen) | dataExt;
      OP_CLEAR: req = REQ_W'(oldLen) & ~dataExt;
      default:  req = '0;
    endcase
    if (req == '0)                 newLenField = '0;
    else if (req > REQ_W'(limit))  newLenField = limitM1[FIELD_W-1:0];
    else                           newLenField = FIELD_W'(req - REQ_W'(1));

    case (stb.op)
      OP_SET:   wordNext = st | swData[WORD_W-1:0];
      OP_CLEAR: wordNext = st & ~swData[WORD_W-1:0];
      default:  wordNext = swData[WORD_W-1:0];
    endcase

    swResult = st;
    case (stb.tgt)
      TGT_WORD:  swResult = stateWord_t'(wordNext);
      TGT_VL:    swResult.curLen = newLenField;
      TGT_MAXVL: swResult.maxLen = newLenField;
      default:   swResult = st;
    endcase

    loopResult         = st;
    loopResult.srcOffs = loopSrcOffs;
    loopResult.dstOffs = loopDstOffs;
    loopResult.srcSub  = loopSrcSub;
    loopResult.dstSub  = loopDstSub;

    if (stb.takeSwap)      nextRaw = stateWord_t'(swapIn);
    else if (stb.takeSw)   nextRaw = swResult;
    else if (stb.takeLoop) nextRaw = loopResult;
    else                   nextRaw = st;
    nextSt = legalize(nextRaw, CAP);

    if ((stb.tgt == TGT_VL || stb.tgt == TGT_MAXVL) && stb.op != OP_NONE)
      lenOut = {1'b0, newLenField} + LEN_W'(1);
    else
      lenOut = '0;

    case (stb.tgt)
      TGT_WORD:  rdData = DATA_W'(st);
      TGT_VL:    rdData = DATA_W'(curAct);
      TGT_MAXVL: rdData = DATA_W'(maxAct);
      default:   rdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= RESET_WORD;
    else       st <= nextSt;
  end

  assign stateOut = st;
  assign vlLen    = {1'b0, st.curLen} + LEN_W'(1);
  assign maxLen   = {1'b0, st.maxLen} + LEN_W'(1);

  // R3: current length never above the maximum
  assert_vl_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    vlLen <= maxLen);

  // R8: the two top bits stay clear
  assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    stateOut[31:30] == 2'b00);

  // R4: the returned length is the one stored
  assert_len_result_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeSw && stb.tgt == TGT_VL) |=> (vlLen == $past(lenOut)));

  // R5: maximum-length write stores the returned value
  assert_max_result_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeSw && stb.tgt == TGT_MAXVL) |=> (maxLen == $past(lenOut)));

  // R11: an in-range shadow maximum is loaded unchanged
  assert_swap_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeSwap && swapIn[5:0] <= CAP) |=> (stateOut[5:0] == $past(swapIn[5:0])));

  // R10: with no source selected the word holds
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.takeSwap || stb.takeSw || stb.takeLoop) |=> $stable(stateOut));
endmodule

// File: rtl/vlen_state_csr.sv
module vlen_state_csr
  import vls_pkg::*;
#(
  parameter int MAXLEN = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swEn,
  input  logic [1:0]        swOp,
  input  logic [1:0]        swTarget,
  input  logic              swImm,
  input  logic [DATA_W-1:0] swData,
  output logic [DATA_W-1:0] rdData,
  output logic [6:0]        lenOut,
  input  logic              loopEn,
  input  logic [5:0]        loopSrcOffs,
  input  logic [5:0]        loopDstOffs,
  input  logic [1:0]        loopSrcSub,
  input  logic [1:0]        loopDstSub,
  input  logic              swapEn,
  input  logic [31:0]       swapIn,
  output logic [31:0]       stateOut,
  output logic [6:0]        vlLen,
  output logic [6:0]        maxLen
);
  strobe_t stb;

  vls_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swEn(swEn), .swOp(swOp), .swTarget(swTarget),
    .swImm(swImm), .loopEn(loopEn), .swapEn(swapEn), .stb(stb)
  );

  vls_datapath #(.MAXLEN(MAXLEN), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .swData(swData),
    .loopSrcOffs(loopSrcOffs), .loopDstOffs(loopDstOffs),
    .loopSrcSub(loopSrcSub), .loopDstSub(loopDstSub), .swapIn(swapIn),
    .rdData(rdData), .lenOut(lenOut), .stateOut(stateOut),
    .vlLen(vlLen), .maxLen(maxLen)
  );
endmodule

// File: tb/sim_vlen_state_csr.sv
`timescale 1ns/1ps
module sim_vlen_state_csr;
  localparam int MAXLEN = 64;
  localparam int DATA_W = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swEn = 0, swImm = 0, loopEn = 0, swapEn = 0;
  logic [1:0] swOp = 2'd3, swTarget = 2'd3;
  logic [DATA_W-1:0] swData = '0;
  logic [5:0] loopSrcOffs = 0, loopDstOffs = 0;
  logic [1:0] loopSrcSub = 0, loopDstSub = 0;
  logic [31:0] swapIn = '0;
  logic [DATA_W-1:0] rdData;
  logic [6:0] lenOut, vlLen, maxLen;
  logic [31:0] stateOut;

  int errors = 0, checks = 0;
  bit finished = 0;
  // model fields (stored-value domain)
  int mx, vl, so, dso, sb, ss, ds;

  always #2 clk = ~clk;

  vlen_state_csr #(.MAXLEN(MAXLEN), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .swEn(swEn), .swOp(swOp), .swTarget(swTarget), .swImm(swImm),
    .swData(swData), .rdData(rdData), .lenOut(lenOut), .loopEn(loopEn),
    .loopSrcOffs(loopSrcOffs), .loopDstOffs(loopDstOffs), .loopSrcSub(loopSrcSub),
    .loopDstSub(loopDstSub), .swapEn(swapEn), .swapIn(swapIn), .stateOut(stateOut),
    .vlLen(vlLen), .maxLen(maxLen)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int packW();
    return mx | (vl << 6) | (so << 12) | (dso << 18) | (sb << 24) | (ss << 26) | (ds << 28);
  endfunction

  function automatic void unpackW(input int unsigned w);
    mx = w & 63; vl = (w >> 6) & 63; so = (w >> 12) & 63; dso = (w >> 18) & 63;
    sb = (w >> 24) & 3; ss = (w >> 26) & 3; ds = (w >> 28) & 3;
  endfunction

  function automatic void fixModel();
    if (mx > MAXLEN - 1) mx = MAXLEN - 1;
    if (vl > mx) vl = mx;
    if (so > vl) so = vl;
    if (dso > vl) dso = vl;
    if (ss > sb) ss = sb;
    if (ds > sb) ds = sb;
  endfunction

  // One clock: drive, check the combinational outputs, advance model, compare state.
  task automatic step(input string tag, input bit en, input int op, input int tgt, input bit imm,
                      input longint unsigned data, input bit lEn, input int lso, input int lds,
                      input int lss, input int lsd, input bit sEn, input int unsigned sIn);
    longint unsigned req, oldLen, limit;
    int newF, expLen;
    longint expRd;
    @(negedge clk);
    swEn = en; swOp = 2'(op); swTarget = 2'(tgt); swImm = imm; swData = data;
    loopEn = lEn; loopSrcOffs = 6'(lso); loopDstOffs = 6'(lds);
    loopSrcSub = 2'(lss); loopDstSub = 2'(lsd); swapEn = sEn; swapIn = sIn;
    #1;
    oldLen = (tgt == 1) ? vl + 1 : mx + 1;
    limit  = (tgt == 1) ? mx + 1 : MAXLEN;
    case (op)
      0: req = data + (imm ? 1 : 0);
      1: req = oldLen | data;
      2: req = oldLen & ~data;
      default: req = 0;
    endcase
    if (req == 0) newF = 0;
    else if (req > limit) newF = int'(limit) - 1;
    else newF = int'(req) - 1;
    expLen = ((tgt == 1 || tgt == 2) && op != 3) ? newF + 1 : 0;
    case (tgt)
      0: expRd = packW();
      1: expRd = vl + 1;
      2: expRd = mx + 1;
      default: expRd = 0;
    endcase
    chk("R12", "rdData", rdData, expRd);
    chk("R4", "lenOut", lenOut, expLen);
    chk("R11", "stateOut before edge", stateOut, packW());
    if (sEn) unpackW(sIn);
    else if (en && op != 3 && tgt != 3) begin
      if (tgt == 0) begin
        case (op)
          1: unpackW(packW() | int'(data[31:0]));
          2: unpackW(packW() & ~int'(data[31:0]));
          default: unpackW(data[31:0]);
        endcase
      end else if (tgt == 1) vl = newF;
      else mx = newF;
    end else if (lEn) begin
      so = lso; dso = lds; ss = lss; ds = lsd;
    end
    fixModel();
    @(posedge clk); #1;
    chk(tag, "stateOut", stateOut, packW());
    chk("R2", "vlLen", vlLen, vl + 1);
    chk("R2", "maxLen", maxLen, mx + 1);
  endtask

  task automatic swAcc(input string tag, input int op, input int tgt, input bit imm, input longint unsigned data);
    step(tag, 1, op, tgt, imm, data, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic idle(input string tag, input int tgt);
    step(tag, 0, 3, tgt, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1: reset word
    chk("R1", "reset word", stateOut, 32'h3F);
    chk("R1", "reset vlLen", vlLen, 1);
    chk("R1", "reset maxLen", maxLen, 64);
    mx = 63; vl = 0; so = 0; dso = 0; sb = 0; ss = 0; ds = 0;
    idle("R1", 0);

    swAcc("R4", 0, 1, 0, 10);           // VL = 10
    idle("R12", 1);                      // read back 10
    swAcc("R4", 0, 1, 0, 100);          // clamp to 64
    chk("R3", "vl clamp", vlLen, 64);
    swAcc("R4", 0, 1, 0, 0);            // zero taken as 1
    chk("R4", "vl zero", vlLen, 1);
    swAcc("R4", 0, 1, 0, 50);
    swAcc("R5", 0, 2, 0, 20);           // maxvl 20 drags vl down
    chk("R5", "vl reduced", vlLen, 20);
    chk("R5", "maxvl", maxLen, 20);
    swAcc("R5", 0, 2, 0, 200);          // cap at MAXLEN
    chk("R5", "maxvl cap", maxLen, 64);
    swAcc("R6", 0, 2, 1, 31);           // imm: 32
    chk("R6", "imm maxvl", maxLen, 32);
    swAcc("R6", 0, 1, 1, 4);            // imm: 5
    chk("R6", "imm vl", vlLen, 5);

    swAcc("R3", 0, 0, 0, 64'hC000_0789); // vl field 30 > maxvl field 9; top bits set
    chk("R3", "packed clamp", stateOut, 32'h249);
    chk("R8", "top bits", stateOut[31:30], 0);
    idle("R8", 0);
    chk("R8", "rdData upper", rdData[63:30], 0);

    swAcc("R9", 0, 0, 0, 64'h2_8249);   // srcoffs 40 > vl field 9
    chk("R9", "offset clamp", stateOut, 32'h9249);

    swAcc("R7", 1, 0, 0, 64'h0300_0000); // set group size to 4
    swAcc("R7", 1, 0, 0, 64'h3C00_0000); // sub-offsets 3
    swAcc("R7", 2, 0, 0, 64'h0200_0000); // group size 2 clamps sub-offsets
    swAcc("R7", 1, 1, 0, 2);            // VL 10 | 2 = 10
    swAcc("R7", 2, 1, 0, 8);            // VL 10 & ~8 = 2
    chk("R7", "clear on length", vlLen, 2);
    swAcc("R7", 2, 1, 0, 7);            // 2 & ~7 = 0 -> 1
    swAcc("R7", 3, 1, 0, 9);            // op none: no change
    swAcc("R5", 0, 2, 0, 64);
    swAcc("R4", 0, 1, 0, 40);

    // R10: loop load and collisions
    step("R10", 0, 3, 0, 0, 0, 1, 12, 33, 1, 0, 0, 0);
    step("R10", 1, 0, 1, 0, 30, 1, 5, 6, 0, 1, 0, 0);   // sw wins
    chk("R10", "loop dropped src", stateOut[17:12], 12);
    step("R10", 1, 0, 3, 0, 7, 1, 5, 6, 0, 1, 0, 0);    // target none: loop proceeds
    chk("R10", "loop applied", stateOut[17:12], 5);

    // R11: swap
    step("R11", 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h1234_5A8F);
    step("R11", 1, 0, 1, 0, 3, 1, 1, 1, 0, 0, 1, 32'h0000_0107);
    chk("R11", "swap wins", stateOut, 32'h107);
    step("R11", 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);

    swAcc("R12", 0, 3, 0, 64'hFFFF);    // no target: ignored, reads 0
    idle("R12", 3);
    idle("R12", 2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule